// File: doc/BRIEF.md
# DMA Operand Request Generator

This block decides, cycle by cycle, whether a single DMA channel has an operand transfer pending. The transfer engine that owns the bus reads the pending flag. It answers with a one-cycle acknowledge when it starts an operand on the channel's behalf, and with a one-cycle completion strobe when that operand finishes. In the completion cycle the block says whether the bus is kept for another operand or released.

Four request sources are selected by a mode field. In the first, the channel asks continuously while it is started. In the second, it asks while started but only until a bus-occupancy budget for the current window is spent. In the third, an external active-low request pin is followed as a level. In the fourth, each falling edge on that pin requests one operand. The block does not arbitrate, count bytes or generate addresses.

Top module: `dma_reqgen`

## Requirements
- R1: While `start_i` is 0, `req_o` is 0 and activity on `ext_req_n` is neither followed nor remembered. A falling edge seen while stopped produces no request once `start_i` returns to 1.
- R2: Mode encoding: `mode_i` 2'b00 is continuous, 2'b01 is budgeted, 2'b10 is level and 2'b11 is edge. In continuous mode `req_o` equals `start_i` in every cycle.
- R3: `rel_o` is 1 only in a cycle where `cmpl_i` is 1, and it is 1 exactly when no request is pending in that cycle (`req_o` is 0).
- R4: In budgeted mode, a cycle counts as busy from the cycle of `ack_i` through the cycle of `cmpl_i`, both included. Once the busy count of the current window reaches the limit, `req_o` stays 0 for the rest of the window. `bw_sel_i` 2'b00, 2'b01, 2'b10 and 2'b11 select limits of 128, 256, 512 and 768 cycles.
- R5: Windows are 1024 cycles long, and the first window starts on the first clock edge after reset. At each window boundary the busy count restarts, and a withheld request becomes pending again.
- R6: In level mode `req_o` is 1 exactly when `start_i` is 1 and `ext_req_n` is 0. In a completion cycle the bus is kept if the pin is still low and released if it is high.
- R7: In edge mode, a high-to-low transition of `ext_req_n` makes `req_o` 1 from the next cycle. Further falling edges before `ack_i` are discarded, and `ack_i` clears the pending request (a falling edge in the acknowledge cycle is discarded too).
- R8: In edge mode, a falling edge after the acknowledge cycle and before the completion cycle keeps the bus at completion. With no such edge, or with the edge only in the completion cycle, the bus is released at completion.
- R9: After reset `req_o` and `rel_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Channel started |
| mode_i | input | 2 | Request source select |
| bw_sel_i | input | 2 | Budget select for budgeted mode |
| ext_req_n | input | 1 | External request pin, active low |
| ack_i | input | 1 | Engine started an operand for this channel (one cycle) |
| cmpl_i | input | 1 | Engine finished the current operand (one cycle) |
| req_o | output | 1 | Operand request pending |
| rel_o | output | 1 | Release the bus in this completion cycle |

## Verification
In edge mode a new falling edge can coincide with the acknowledge, or with the completion, of the operand already being served. The bench places edges exactly in those cycles and in the cycles between them. It then judges from `req_o` and `rel_o` whether the edge was dropped, held over for a later request, or counted toward keeping the bus. In budgeted mode the exhaustion of the budget can meet a window boundary. The bench aligns a window to reset, answers every request with a one-cycle transfer, and counts the acknowledged cycles in each of two consecutive windows against the selected limit.

// File: rtl/dma_reqgen.sv
module dma_reqgen #(
  parameter int WIN_LEN = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] bw_sel_i,
  input  logic       ext_req_n,
  input  logic       ack_i,
  input  logic       cmpl_i,
  output logic       req_o,
  output logic       rel_o
);
  localparam int CW     = $clog2(WIN_LEN);
  localparam int EIGHTH = WIN_LEN / 8;

  localparam logic [1:0] M_CONT  = 2'b00;
  localparam logic [1:0] M_BUDG  = 2'b01;
  localparam logic [1:0] M_LEVEL = 2'b10;
  localparam logic [1:0] M_EDGE  = 2'b11;

  logic [CW-1:0] wcnt_q;
  logic [CW:0]   used_q;
  logic [CW:0]   lim;
  logic          xfer_q;
  logic          prev_n_q;
  logic          pend_q;
  logic          busy, wrap, fall, budget_ok;

  assign busy      = ack_i | xfer_q;
  assign wrap      = wcnt_q == CW'(WIN_LEN - 1);
  assign fall      = prev_n_q & ~ext_req_n;
  assign budget_ok = used_q < lim;

  always_comb begin
    case (bw_sel_i)
      2'b00:   lim = (CW+1)'(EIGHTH);
      2'b01:   lim = (CW+1)'(2 * EIGHTH);
      2'b10:   lim = (CW+1)'(4 * EIGHTH);
      default: lim = (CW+1)'(6 * EIGHTH);
    endcase
  end

  always_comb begin
    case (mode_i)
      M_CONT:  req_o = start_i;
      M_BUDG:  req_o = start_i & budget_ok;
      M_LEVEL: req_o = start_i & ~ext_req_n;
      default: req_o = start_i & pend_q;
    endcase
  end

  assign rel_o = cmpl_i & ~req_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q   <= '0;
      used_q   <= '0;
      xfer_q   <= 1'b0;
      prev_n_q <= 1'b1;
      pend_q   <= 1'b0;
    end else begin
      wcnt_q   <= wrap ? '0 : wcnt_q + 1'b1;
      used_q   <= wrap ? '0 : used_q + (CW+1)'(busy);
      xfer_q   <= (xfer_q | ack_i) & ~cmpl_i;
      prev_n_q <= ext_req_n;
      if (!start_i || mode_i != M_EDGE || ack_i)
        pend_q <= 1'b0;
      else if (fall)
        pend_q <= 1'b1;
    end
  end
endmodule

module dma_reqgen_chk #(
  parameter int WIN_LEN = 1024
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start_i,
  input logic [1:0]                  mode_i,
  input logic                        ext_req_n,
  input logic                        ack_i,
  input logic                        cmpl_i,
  input logic                        req_o,
  input logic                        rel_o,
  input logic [$clog2(WIN_LEN)-1:0]  wcnt_q,
  input logic [$clog2(WIN_LEN):0]    used_q
);
  a_r1_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |-> !req_o);
  a_r2_cont_always: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i == 2'b00) |-> req_o);
  a_r3_release_at_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o |-> cmpl_i);
  a_r5_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt_q == '1) |=> (used_q == '0));
  a_r6_level_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && start_i && mode_i == 2'b10 && !ext_req_n) |-> !rel_o);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && mode_i == 2'b11 && $stable(mode_i)) |=> !req_o);
endmodule

bind dma_reqgen dma_reqgen_chk #(.WIN_LEN(WIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
  .ext_req_n(ext_req_n), .ack_i(ack_i), .cmpl_i(cmpl_i),
  .req_o(req_o), .rel_o(rel_o), .wcnt_q(wcnt_q), .used_q(used_q)
);

// File: tb/dma_reqgen_test.sv
module dma_reqgen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start_i = 0, ext_req_n = 1, ack_i = 0, cmpl_i = 0;
  logic [1:0] mode_i = 2'b00, bw_sel_i = 2'b00;
  logic req_o, rel_o;
  int checks = 0, fails = 0;

  dma_reqgen uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; start_i = 0; ext_req_n = 1; ack_i = 0; cmpl_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(req_o == 0, "R9 req after reset", req_o, 0);
    check(rel_o == 0, "R9 rel after reset", rel_o, 0);
  endtask

  task automatic t_cont();
    mode_i = 2'b00; start_i = 1; #1;
    check(req_o == 1, "R2 cont req", req_o, 1);
    @(negedge clk); cmpl_i = 1; #1;
    check(rel_o == 0, "R3 cont keep", rel_o, 0);
    start_i = 0; #1;
    check(req_o == 0, "R1 cont stopped", req_o, 0);
    check(rel_o == 1, "R3 cont release", rel_o, 1);
    @(negedge clk); cmpl_i = 0;
  endtask

  task automatic t_level();
    mode_i = 2'b10; start_i = 0; ext_req_n = 0; #1;
    check(req_o == 0, "R1 level ignored stopped", req_o, 0);
    start_i = 1; #1;
    check(req_o == 1, "R6 level req", req_o, 1);
    @(negedge clk); ack_i = 1;
    @(negedge clk); ack_i = 0;
    @(negedge clk); cmpl_i = 1; #1;
    check(rel_o == 0, "R6 level keep", rel_o, 0);
    @(negedge clk); cmpl_i = 0; ack_i = 1;
    @(negedge clk); ack_i = 0; ext_req_n = 1;
    @(negedge clk); cmpl_i = 1; #1;
    check(rel_o == 1, "R6 level release", rel_o, 1);
    check(req_o == 0, "R6 level idle", req_o, 0);
    @(negedge clk); cmpl_i = 0; start_i = 0;
  endtask

  task automatic t_edge();
    mode_i = 2'b11; start_i = 0;
    @(negedge clk); ext_req_n = 0;
    @(negedge clk); ext_req_n = 1; start_i = 1;
    @(negedge clk); #1;
    check(req_o == 0, "R1 edge while stopped dropped", req_o, 0);
    ext_req_n = 0;
    @(negedge clk); #1;
    check(req_o == 1, "R7 edge request", req_o, 1);
    ext_req_n = 1;
    @(negedge clk); ext_req_n = 0;
    @(negedge clk); ext_req_n = 1; ack_i = 1;
    @(negedge clk); ack_i = 0; #1;
    check(req_o == 0, "R7 extra edge discarded", req_o, 0);
    @(negedge clk); cmpl_i = 1; #1;
    check(rel_o == 1, "R8 no edge release", rel_o, 1);
    @(negedge clk); cmpl_i = 0; ext_req_n = 0;
    @(negedge clk); #1;
    check(req_o == 1, "R7 second request", req_o, 1);
    ext_req_n = 1;
    @(negedge clk); ack_i = 1; ext_req_n = 0;
    @(negedge clk); ack_i = 0; ext_req_n = 1; #1;
    check(req_o == 0, "R7 edge in ack cycle dropped", req_o, 0);
    @(negedge clk); ext_req_n = 0;
    @(negedge clk); ext_req_n = 1; cmpl_i = 1; #1;
    check(rel_o == 0, "R8 edge before cmpl keeps bus", rel_o, 0);
    @(negedge clk); cmpl_i = 0; ack_i = 1;
    @(negedge clk); ack_i = 0;
    @(negedge clk); cmpl_i = 1; ext_req_n = 0; #1;
    check(rel_o == 1, "R8 edge in cmpl cycle releases", rel_o, 1);
    @(negedge clk); cmpl_i = 0; ext_req_n = 1; #1;
    check(req_o == 1, "R8 late edge served later", req_o, 1);
    start_i = 0;
    @(negedge clk);
  endtask

  task automatic t_budget(input logic [1:0] sel, input int lim);
    int cnt;
    mode_i = 2'b01; bw_sel_i = sel;
    do_reset();
    start_i = 1;
    for (int w = 0; w < 2; w++) begin
      cnt = 0;
      for (int i = 0; i < 1024; i++) begin
        #1;
        if (i == 1000) check(req_o == 0, "R4 withheld late in window", req_o, 0);
        ack_i = req_o; cmpl_i = req_o;
        if (req_o) cnt++;
        @(negedge clk);
      end
      ack_i = 0; cmpl_i = 0;
      check(cnt == lim, w == 0 ? "R4 busy cycles window" : "R5 busy cycles next window", cnt, lim);
    end
    start_i = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_cont();
        t_level();
        t_edge();
        t_budget(2'b00, 128);
        t_budget(2'b11, 768);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule